// File: doc/BRIEF.md
# Calendar Shadow Register Read Lock

This block sits between a free-running calendar counter (sub-second count, time of day and date) and a simple register-read port. When live mode is off, each read returns a shadow copy instead of the counter itself. The shadow copies take fresh counter values whenever the periodic update pulse arrives. Software reads the three registers from the finest field to the coarsest. Reading the sub-second register freezes the time and date copies, and reading the time register freezes the date copy. The fields software gathers therefore all come from one calendar instant, even when an update pulse lands in the middle of the sequence.

Reading the date register releases every freeze, and the frozen copies then catch up on the next update pulse. When live mode is on, every read returns the counter value present at the read edge, and no freeze is ever set.

A read is a one-cycle strobe with a register select. The data comes back on the following cycle together with a valid flag. Reset is synchronous and active low. During reset the shadows load directly from the counters.

Top module: `calShadowLock`

## Requirements
- R1: A read strobe with select 0 (sub-second), 1 (time) or 2 (date) raises the valid flag exactly one cycle later, with the selected value zero-extended on the data output. Select 3 returns zero. With no strobe, the valid flag stays low.
- R2: With live mode off, a read returns the shadow value held just before the read edge. Each shadow that is not frozen loads its counter on every update pulse.
- R3: With live mode off, a sub-second read freezes both the time and date shadows. Frozen shadows ignore update pulses.
- R4: With live mode off, a time read freezes the date shadow only.
- R5: With live mode on, a read returns the live counter value present at the read edge. No freeze is set, and any existing freezes are cleared.
- R6: A date read clears both freezes. A previously frozen shadow then loads on the next update pulse.
- R7: When an update pulse and a freezing read share a cycle, the freeze wins for the frozen shadows. A sub-second, time, date read sequence returns fields taken at one instant, whatever the placement of update pulses around it.
- R8: While reset is low, all three shadows load from the counters, both freezes clear and the valid flag is low.
- R9: The sub-second shadow is never frozen and follows every update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| liveMode | input | 1 | 1 = reads bypass the shadows |
| updatePulse | input | 1 | Shadow refresh strobe |
| cntSub | input | SUB_W | Live sub-second count |
| cntTime | input | TIME_W | Live time-of-day count |
| cntDate | input | DATE_W | Live date count |
| rdEn | input | 1 | One-cycle read strobe |
| rdSel | input | 2 | Register select: 0 sub, 1 time, 2 date |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | DATA_W | Read data, zero-extended |

## Verification
A freeze state that is wrong shows up as a time or date value from a newer instant than the sub-second value read before it. That error is visible one cycle after the later read in the sequence. A freeze that is never released shows up as a stale date or time on the first read after the next update pulse. The bench sweeps every pattern of update pulses over an eight-cycle window around a sub-second, time, date read sequence. It also sweeps every select in both modes, with and without a coinciding pulse. It compares each returned word against a cycle-level model built from the requirements.

// File: rtl/calShadowPkg.sv
package calShadowPkg;

  typedef enum logic [1:0] {
    SEL_SUB  = 2'd0,
    SEL_TIME = 2'd1,
    SEL_DATE = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadSub;
    logic    loadTime;
    logic    loadDate;
    logic    capture;
    logic    useLive;
    regSel_e sel;
  } calStrobes_t;

endpackage

// File: rtl/calShadowCtrl.sv
module calShadowCtrl
  import calShadowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        liveMode,
  input  logic        updatePulse,
  input  logic        rdEn,
  input  logic [1:0]  rdSel,
  output calStrobes_t strobes,
  output logic        timeLock,
  output logic        dateLock
);

  regSel_e sel;
  logic subRd, timeRd, dateRd;
  logic timeHold, dateHold;

  assign sel    = regSel_e'(rdSel);
  assign subRd  = rdEn && (sel == SEL_SUB)  && !liveMode;
  assign timeRd = rdEn && (sel == SEL_TIME) && !liveMode;
  assign dateRd = rdEn && (sel == SEL_DATE);

  // a freezing read in the same cycle as a pulse wins over the pulse
  assign timeHold = !liveMode && (timeLock || subRd);
  assign dateHold = !liveMode && (dateLock || subRd || timeRd);

  always_comb begin
    strobes.loadSub  = updatePulse;
    strobes.loadTime = updatePulse && !timeHold;
    strobes.loadDate = updatePulse && !dateHold;
    strobes.capture  = rdEn;
    strobes.useLive  = liveMode;
    strobes.sel      = sel;
  end

  always_ff @(posedge clk) begin
    if (!rstN || liveMode || dateRd) begin
      timeLock <= 1'b0;
      dateLock <= 1'b0;
    end else begin
      timeLock <= timeLock || subRd;
      dateLock <= dateLock || subRd || timeRd;
    end
  end

endmodule

// File: rtl/calShadowData.sv
module calShadowData
  import calShadowPkg::*;
#(
  parameter int SUB_W  = 16,
  parameter int TIME_W = 20,
  parameter int DATE_W = 24,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobes_t       strobes,
  input  logic [SUB_W-1:0]  cntSub,
  input  logic [TIME_W-1:0] cntTime,
  input  logic [DATE_W-1:0] cntDate,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  logic [SUB_W-1:0]  shSub;
  logic [TIME_W-1:0] shTime;
  logic [DATE_W-1:0] shDate;
  logic [DATA_W-1:0] readMux;

  always_comb begin
    unique case (strobes.sel)
      SEL_SUB:  readMux = DATA_W'(strobes.useLive ? cntSub  : shSub);
      SEL_TIME: readMux = DATA_W'(strobes.useLive ? cntTime : shTime);
      SEL_DATE: readMux = DATA_W'(strobes.useLive ? cntDate : shDate);
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shSub   <= cntSub;
      shTime  <= cntTime;
      shDate  <= cntDate;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobes.loadSub)  shSub  <= cntSub;
      if (strobes.loadTime) shTime <= cntTime;
      if (strobes.loadDate) shDate <= cntDate;
      rdValid <= strobes.capture;
      if (strobes.capture) rdData <= readMux;
    end
  end

endmodule

// File: rtl/calShadowLock.sv
module calShadowLock
  import calShadowPkg::*;
#(
  parameter int SUB_W  = 16,
  parameter int TIME_W = 20,
  parameter int DATE_W = 24,
  localparam int WIDE_W = (SUB_W > TIME_W) ? SUB_W : TIME_W,
  localparam int DATA_W = (WIDE_W > DATE_W) ? WIDE_W : DATE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              liveMode,
  input  logic              updatePulse,
  input  logic [SUB_W-1:0]  cntSub,
  input  logic [TIME_W-1:0] cntTime,
  input  logic [DATE_W-1:0] cntDate,
  input  logic              rdEn,
  input  logic [1:0]        rdSel,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  calStrobes_t strobes;
  logic timeLock, dateLock;

  calShadowCtrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .liveMode    (liveMode),
    .updatePulse (updatePulse),
    .rdEn        (rdEn),
    .rdSel       (rdSel),
    .strobes     (strobes),
    .timeLock    (timeLock),
    .dateLock    (dateLock)
  );

  calShadowData #(
    .SUB_W  (SUB_W),
    .TIME_W (TIME_W),
    .DATE_W (DATE_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cntSub  (cntSub),
    .cntTime (cntTime),
    .cntDate (cntDate),
    .rdValid (rdValid),
    .rdData  (rdData)
  );

endmodule

// File: rtl/calShadowLockChk.sv
module calShadowLockChk #(
  parameter int SUB_W  = 16,
  parameter int TIME_W = 20,
  parameter int DATE_W = 24,
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              liveMode,
  input logic [SUB_W-1:0]  cntSub,
  input logic [TIME_W-1:0] cntTime,
  input logic [DATE_W-1:0] cntDate,
  input logic              rdEn,
  input logic [1:0]        rdSel,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic              timeLock,
  input logic              dateLock
);

  logic [DATA_W-1:0] liveWord;
  always_comb begin
    case (rdSel)
      2'd0:    liveWord = DATA_W'(cntSub);
      2'd1:    liveWord = DATA_W'(cntTime);
      2'd2:    liveWord = DATA_W'(cntDate);
      default: liveWord = '0;
    endcase
  end

  p_valid_follows_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  p_no_spurious_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  p_sub_read_freezes_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd0 && !liveMode) |=> (timeLock && dateLock));

  p_time_read_freezes_date_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd1 && !liveMode) |=> dateLock);

  p_live_read_value_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && liveMode) |=> (rdData == $past(liveWord) && !timeLock && !dateLock));

  p_date_read_releases_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 2'd2) |=> (!timeLock && !dateLock));

  // R3: time freeze never exists without date freeze
  p_lock_order_r3: assert property (@(posedge clk) disable iff (!rstN)
    timeLock |-> dateLock);

endmodule

bind calShadowLock calShadowLockChk #(
  .SUB_W  (SUB_W),
  .TIME_W (TIME_W),
  .DATE_W (DATE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .liveMode (liveMode),
  .cntSub   (cntSub),
  .cntTime  (cntTime),
  .cntDate  (cntDate),
  .rdEn     (rdEn),
  .rdSel    (rdSel),
  .rdValid  (rdValid),
  .rdData   (rdData),
  .timeLock (timeLock),
  .dateLock (dateLock)
);

// File: tb/calShadowLock_test.sv
`timescale 1ns/1ps
module calShadowLock_test;

  localparam int SUB_W  = 16;
  localparam int TIME_W = 20;
  localparam int DATE_W = 24;
  localparam int DATA_W = 24;

  logic clk = 1'b0;
  logic rstN, liveMode, updatePulse, rdEn;
  logic [1:0] rdSel;
  logic [SUB_W-1:0]  cntSub;
  logic [TIME_W-1:0] cntTime;
  logic [DATE_W-1:0] cntDate;
  logic rdValid;
  logic [DATA_W-1:0] rdData;

  always #2 clk = ~clk;  // 250 MHz

  calShadowLock #(.SUB_W(SUB_W), .TIME_W(TIME_W), .DATE_W(DATE_W)) uut (
    .clk(clk), .rstN(rstN), .liveMode(liveMode), .updatePulse(updatePulse),
    .cntSub(cntSub), .cntTime(cntTime), .cntDate(cntDate),
    .rdEn(rdEn), .rdSel(rdSel), .rdValid(rdValid), .rdData(rdData)
  );

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  bit finished = 0;
  string curReq = "R8";

  // reference model state
  logic [SUB_W-1:0]  mSub;
  logic [TIME_W-1:0] mTime;
  logic [DATE_W-1:0] mDate;
  bit mTimeLk, mDateLk;
  bit expValid;
  logic [DATA_W-1:0] expData;

  task automatic check(input string req, input bit ok, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit rst, input bit live, input bit upd, input bit rd,
                      input logic [1:0] sel);
    bit subRd, timeRd, dateRd, tHold, dHold;
    @(negedge clk);
    cyc++;
    rstN = !rst; liveMode = live; updatePulse = upd; rdEn = rd; rdSel = sel;
    cntSub  = SUB_W'(cyc * 5 + 3);
    cntTime = TIME_W'(cyc * 13 + 7);
    cntDate = DATE_W'(cyc * 29 + 11);
    if (rst) begin
      mSub = cntSub; mTime = cntTime; mDate = cntDate;
      mTimeLk = 0; mDateLk = 0; expValid = 0;
    end else begin
      expValid = rd;
      if (rd) begin
        case (sel)
          2'd0: expData = DATA_W'(live ? cntSub  : mSub);
          2'd1: expData = DATA_W'(live ? cntTime : mTime);
          2'd2: expData = DATA_W'(live ? cntDate : mDate);
          default: expData = '0;
        endcase
      end
      subRd  = rd && sel == 2'd0 && !live;
      timeRd = rd && sel == 2'd1 && !live;
      dateRd = rd && sel == 2'd2;
      tHold = !live && (mTimeLk || subRd);
      dHold = !live && (mDateLk || subRd || timeRd);
      if (upd) begin
        mSub = cntSub;
        if (!tHold) mTime = cntTime;
        if (!dHold) mDate = cntDate;
      end
      if (live || dateRd) begin
        mTimeLk = 0; mDateLk = 0;
      end else begin
        mTimeLk = mTimeLk || subRd;
        mDateLk = mDateLk || subRd || timeRd;
      end
    end
    @(posedge clk);
    #1;
    check({curReq, " valid"}, rdValid == expValid, DATA_W'(rdValid), DATA_W'(expValid));
    if (expValid) check({curReq, " data"}, rdData == expData, rdData, expData);
  endtask

  initial begin
    rstN = 0; liveMode = 0; updatePulse = 0; rdEn = 0; rdSel = 0;
    cntSub = '0; cntTime = '0; cntDate = '0;
    mSub = '0; mTime = '0; mDate = '0; mTimeLk = 0; mDateLk = 0;
    expValid = 0; expData = '0;

    // R8: reset loads shadows, clears freezes, valid low (read strobe ignored)
    curReq = "R8";
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 2'd0);
    for (int s = 0; s < 3; s++) step(0, 0, 0, 1, 2'(s));
    step(0, 0, 0, 1, 2'd2);

    // R1, R2, R5: every select, both modes, with and without a pulse
    for (int lv = 0; lv < 2; lv++)
      for (int up = 0; up < 2; up++)
        for (int s = 0; s < 4; s++) begin
          curReq = (lv != 0) ? "R5" : ((s == 3) ? "R1" : "R2");
          step(0, lv[0], up[0], 1, 2'(s));
          curReq = "R1";
          step(0, lv[0], 0, 0, 2'd0);
          step(0, 0, 1, 1, 2'd2);
        end

    // R3, R4, R7: every pulse pattern around a sub, time, date sequence
    curReq = "R7";
    for (int m = 0; m < 256; m++) begin
      for (int c = 0; c < 8; c++) begin
        bit rd;
        logic [1:0] sel;
        rd = (c == 2) || (c == 4) || (c == 6);
        sel = (c == 2) ? 2'd0 : ((c == 4) ? 2'd1 : 2'd2);
        curReq = (c == 4) ? "R3" : ((c == 6) ? "R4" : "R7");
        step(0, 0, m[c], rd, sel);
      end
      step(0, 0, 1, 0, 2'd0);
    end

    // R4: time read alone freezes date, time keeps following
    curReq = "R4";
    step(0, 0, 1, 1, 2'd1);
    step(0, 0, 1, 1, 2'd1);
    step(0, 0, 1, 1, 2'd2);
    // R6: after release the date catches up on the next pulse
    curReq = "R6";
    step(0, 0, 1, 0, 2'd0);
    step(0, 0, 0, 1, 2'd2);

    // R9: sub shadow follows pulses while frozen
    curReq = "R9";
    step(0, 0, 1, 1, 2'd0);
    step(0, 0, 1, 0, 2'd0);
    step(0, 0, 1, 1, 2'd0);
    step(0, 0, 0, 1, 2'd0);
    // R5: live mode clears freezes
    curReq = "R5";
    step(0, 1, 0, 1, 2'd1);
    curReq = "R6";
    step(0, 0, 1, 0, 2'd0);
    step(0, 0, 0, 1, 2'd1);
    step(0, 0, 0, 1, 2'd2);

    // R8: reset mid-freeze
    curReq = "R8";
    step(0, 0, 0, 1, 2'd0);
    step(1, 0, 0, 0, 2'd0);
    step(0, 0, 1, 1, 2'd1);
    step(0, 0, 0, 1, 2'd2);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule